// File: doc/BRIEF.md
# Software-Filled Dual-Page Translation Buffer

This block is a fully associative address translation buffer whose contents are written only by software. It never walks page tables and never reads memory on its own. Each entry holds one tag that covers a pair of neighbouring virtual pages, plus two physical frame descriptors, one for the even page of the pair and one for the odd page. Every entry chooses its own page size from ten sizes between 1 KB and 256 MB, each four times the one below it.

A lookup presents a virtual address, an address-space identifier and a load/store flag. One cycle later the block returns either a physical address or an exception code. Software then handles refills, invalid pages and first writes to clean pages. Three more ports let software write an entry at a chosen index, read an entry back at a chosen index, and probe for the index of an entry that matches a given tag. The probe port also keeps a sticky flag that records when more than one entry matched.

Top module: `sw_tlb`

## Requirements
- R1: The entry count N is a parameter from 1 to 64. A write whose index is N or more changes nothing, and reading such an index returns all-zero fields.
- R2: Size code s (0 to 9, with larger codes acting as 9) gives a page of 2^(10+2s) bytes. On a hit, physical address bits below 10+2s are copied from the virtual address, and the bits above them come from the selected frame number shifted left by 10.
- R3: Virtual address bit 10+2s selects the half of a matching entry: 0 selects the even-page descriptor and 1 selects the odd-page descriptor.
- R4: An entry matches when the virtual address bits above 10+2s equal the stored tag (the tag holds address bits 31..11), and when either its global bit is set or its stored address-space ID equals the request's.
- R5: When no entry matches, the lookup reports refill, with code 4 for a load and code 5 for a store, and a physical address of zero.
- R6: A store that hits a valid half whose dirty bit is clear reports code 1 (modified) and a physical address of zero. A store to a dirty half reports code 0.
- R7: A hit on a half whose valid bit is clear reports code 2 for a load and code 3 for a store, with a physical address of zero.
- R8: A probe reports found and the lowest matching index one cycle after the request, or not-found when nothing matches. A probe that matches two or more entries sets a multiple-match flag, which stays set until reset.
- R9: An indexed write takes a single cycle. A lookup in the same cycle as the write still sees the old contents, and a lookup in the next cycle sees the new ones. The read port returns an entry's fields combinationally.
- R10: A lookup's result and a one-cycle done pulse appear on the clock edge after the request. When several entries match a lookup, the lowest index is used, and a successful lookup returns code 0.
- R11: After reset, every entry field is zero, all lookup and probe outputs are zero, and the multiple-match flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_st | input | 1 | Lookup is a store |
| lk_done | output | 1 | Lookup result valid (one-cycle pulse) |
| lk_pa | output | PA_W | Translated physical address |
| lk_exc | output | 3 | Exception code (0 none, 1 modified, 2/3 invalid load/store, 4/5 refill load/store) |
| wr_en | input | 1 | Indexed entry write |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn2 | input | VA_W-11 | Tag: virtual address bits above 10 |
| wr_size | input | 4 | Page size code |
| wr_asid | input | ASID_W | Entry address-space ID |
| wr_g | input | 1 | Global bit |
| wr_pfn0 | input | PA_W-10 | Even-page frame number |
| wr_v0 | input | 1 | Even-page valid |
| wr_d0 | input | 1 | Even-page dirty |
| wr_pfn1 | input | PA_W-10 | Odd-page frame number |
| wr_v1 | input | 1 | Odd-page valid |
| wr_d1 | input | 1 | Odd-page dirty |
| rd_idx | input | IDX_W | Entry index to read |
| rd_vpn2 | output | VA_W-11 | Read tag |
| rd_size | output | 4 | Read size code |
| rd_asid | output | ASID_W | Read address-space ID |
| rd_g | output | 1 | Read global bit |
| rd_pfn0 | output | PA_W-10 | Read even frame |
| rd_v0 | output | 1 | Read even valid |
| rd_d0 | output | 1 | Read even dirty |
| rd_pfn1 | output | PA_W-10 | Read odd frame |
| rd_v1 | output | 1 | Read odd valid |
| rd_d1 | output | 1 | Read odd dirty |
| pr_req | input | 1 | Probe request |
| pr_vpn2 | input | VA_W-11 | Probe tag |
| pr_asid | input | ASID_W | Probe address-space ID |
| pr_done | output | 1 | Probe result valid |
| pr_found | output | 1 | Probe found a match |
| pr_idx | output | IDX_W | Lowest matching index |
| mm_err | output | 1 | Sticky multiple-match flag |

## Verification
Lookup and probe results are registered, so each one is due exactly one clock edge after its request. Each task drives a request just after a falling edge and reads the outputs at the next falling edge, half a period after the capturing rising edge. Writes land on the rising edge that follows the falling edge at which they are driven. The same-cycle case drives a write and a lookup together and expects the old contents, then looks up again one cycle later and expects the new ones. The read port has no register, so it is sampled a short delay after its index changes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int OFF_MIN  = 10;               // smallest page offset (1 KB)
   localparam int SIZE_MAX = 9;                // largest size code (256 MB)
   localparam int OFF_TOP  = OFF_MIN + 2*SIZE_MAX;

   typedef enum logic [2:0] {
      EXC_NONE   = 3'd0,
      EXC_MOD    = 3'd1,
      EXC_INV_LD = 3'd2,
      EXC_INV_ST = 3'd3,
      EXC_RFL_LD = 3'd4,
      EXC_RFL_ST = 3'd5
   } exc_e;

   function automatic logic [3:0] size_clamp(input logic [3:0] s);
      return (s > 4'(SIZE_MAX)) ? 4'(SIZE_MAX) : s;
   endfunction
endpackage

// File: rtl/tlb_cmp.sv
module tlb_cmp
   import tlb_pkg::*;
#(
   parameter int ASID_W = 8,
   parameter int VPN2_W = 21
) (
   input  logic [VPN2_W-1:0] e_vpn2,
   input  logic [3:0]        e_size,
   input  logic [ASID_W-1:0] e_asid,
   input  logic              e_g,
   input  logic [VPN2_W-1:0] vtag,
   input  logic [ASID_W-1:0] asid,
   output logic              hit
);
   logic [3:0]        s_eff;
   logic [VPN2_W-1:0] cmp_mask;

   always_comb begin
      s_eff    = size_clamp(e_size);
      // tag bits covered by the page (and its pair bit) are not compared
      cmp_mask = {VPN2_W{1'b1}} << {s_eff, 1'b0};
      hit      = (((vtag ^ e_vpn2) & cmp_mask) == '0) && (e_g || (e_asid == asid));
   end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic             multi,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
      any   = |hits;
      multi = (hits & (hits - N'(1))) != '0;
   end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
   import tlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int ASID_W = 8,
   parameter int IDX_W  = (N > 1) ? $clog2(N) : 1,
   parameter int VPN2_W = VA_W - OFF_MIN - 1,
   parameter int PFN_W  = PA_W - OFF_MIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_st,
   output logic              lk_done,
   output logic [PA_W-1:0]   lk_pa,
   output logic [2:0]        lk_exc,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [3:0]        wr_size,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_g,
   input  logic [PFN_W-1:0]  wr_pfn0,
   input  logic              wr_v0,
   input  logic              wr_d0,
   input  logic [PFN_W-1:0]  wr_pfn1,
   input  logic              wr_v1,
   input  logic              wr_d1,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [VPN2_W-1:0] rd_vpn2,
   output logic [3:0]        rd_size,
   output logic [ASID_W-1:0] rd_asid,
   output logic              rd_g,
   output logic [PFN_W-1:0]  rd_pfn0,
   output logic              rd_v0,
   output logic              rd_d0,
   output logic [PFN_W-1:0]  rd_pfn1,
   output logic              rd_v1,
   output logic              rd_d1,
   input  logic              pr_req,
   input  logic [VPN2_W-1:0] pr_vpn2,
   input  logic [ASID_W-1:0] pr_asid,
   output logic              pr_done,
   output logic              pr_found,
   output logic [IDX_W-1:0]  pr_idx,
   output logic              mm_err
);
   // elaboration-time parameter checks
   if (N < 1 || N > 64) begin : g_bad_n
      $error("sw_tlb: N must lie in 1..64");
   end
   if (VA_W < OFF_TOP + 1) begin : g_bad_va
      $error("sw_tlb: VA_W too small for the largest page pair");
   end
   if (PA_W < OFF_TOP || PA_W <= OFF_MIN) begin : g_bad_pa
      $error("sw_tlb: PA_W too small for the largest page");
   end
   if (ASID_W < 1) begin : g_bad_asid
      $error("sw_tlb: ASID_W must be positive");
   end

   // entry storage
   logic [VPN2_W-1:0] t_vpn2 [N];
   logic [3:0]        t_size [N];
   logic [ASID_W-1:0] t_asid [N];
   logic              t_g    [N];
   logic [PFN_W-1:0]  t_pfn0 [N];
   logic              t_v0   [N];
   logic              t_d0   [N];
   logic [PFN_W-1:0]  t_pfn1 [N];
   logic              t_v1   [N];
   logic              t_d1   [N];

   logic wr_ok;
   assign wr_ok = wr_en && (int'(wr_idx) < N);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            t_vpn2[i] <= '0; t_size[i] <= '0; t_asid[i] <= '0; t_g[i] <= 1'b0;
            t_pfn0[i] <= '0; t_v0[i]   <= 1'b0; t_d0[i] <= 1'b0;
            t_pfn1[i] <= '0; t_v1[i]   <= 1'b0; t_d1[i] <= 1'b0;
         end
      end else if (wr_ok) begin
         t_vpn2[wr_idx] <= wr_vpn2; t_size[wr_idx] <= wr_size;
         t_asid[wr_idx] <= wr_asid; t_g[wr_idx]    <= wr_g;
         t_pfn0[wr_idx] <= wr_pfn0; t_v0[wr_idx]   <= wr_v0; t_d0[wr_idx] <= wr_d0;
         t_pfn1[wr_idx] <= wr_pfn1; t_v1[wr_idx]   <= wr_v1; t_d1[wr_idx] <= wr_d1;
      end
   end

   // indexed read, combinational
   logic rd_ok;
   assign rd_ok = int'(rd_idx) < N;

   always_comb begin
      rd_vpn2 = '0; rd_size = '0; rd_asid = '0; rd_g = 1'b0;
      rd_pfn0 = '0; rd_v0 = 1'b0; rd_d0 = 1'b0;
      rd_pfn1 = '0; rd_v1 = 1'b0; rd_d1 = 1'b0;
      if (rd_ok) begin
         rd_vpn2 = t_vpn2[rd_idx]; rd_size = t_size[rd_idx];
         rd_asid = t_asid[rd_idx]; rd_g    = t_g[rd_idx];
         rd_pfn0 = t_pfn0[rd_idx]; rd_v0   = t_v0[rd_idx]; rd_d0 = t_d0[rd_idx];
         rd_pfn1 = t_pfn1[rd_idx]; rd_v1   = t_v1[rd_idx]; rd_d1 = t_d1[rd_idx];
      end
   end

   // per-entry comparators: one bank for lookups, one for probes
   logic [N-1:0] lk_hits, pr_hits;

   for (genvar i = 0; i < N; i++) begin : g_ent
      tlb_cmp #(.ASID_W(ASID_W), .VPN2_W(VPN2_W)) u_lk (
         .e_vpn2(t_vpn2[i]), .e_size(t_size[i]), .e_asid(t_asid[i]), .e_g(t_g[i]),
         .vtag(lk_va[VA_W-1:OFF_MIN+1]), .asid(lk_asid), .hit(lk_hits[i])
      );
      tlb_cmp #(.ASID_W(ASID_W), .VPN2_W(VPN2_W)) u_pr (
         .e_vpn2(t_vpn2[i]), .e_size(t_size[i]), .e_asid(t_asid[i]), .e_g(t_g[i]),
         .vtag(pr_vpn2), .asid(pr_asid), .hit(pr_hits[i])
      );
   end

   logic             lk_any, lk_multi, pr_any, pr_multi;
   logic [IDX_W-1:0] lk_sel, pr_sel;

   tlb_pick #(.N(N), .IDX_W(IDX_W)) u_pick_lk (
      .hits(lk_hits), .any(lk_any), .multi(lk_multi), .idx(lk_sel)
   );
   tlb_pick #(.N(N), .IDX_W(IDX_W)) u_pick_pr (
      .hits(pr_hits), .any(pr_any), .multi(pr_multi), .idx(pr_sel)
   );

   // translation of the selected entry
   logic [3:0]      s_eff;
   logic [4:0]      off;
   logic            odd, h_v, h_d;
   logic [PFN_W-1:0] h_pfn;
   logic [PA_W-1:0] base, om, va_low, pa_n;
   exc_e            exc_n;

   always_comb begin
      s_eff  = size_clamp(t_size[lk_sel]);
      off    = 5'(OFF_MIN) + {s_eff, 1'b0};
      odd    = lk_va[off];
      h_pfn  = odd ? t_pfn1[lk_sel] : t_pfn0[lk_sel];
      h_v    = odd ? t_v1[lk_sel]   : t_v0[lk_sel];
      h_d    = odd ? t_d1[lk_sel]   : t_d0[lk_sel];
      base   = {h_pfn, {OFF_MIN{1'b0}}};
      om     = (PA_W'(1) << off) - PA_W'(1);
      va_low = PA_W'(lk_va[OFF_TOP-1:0]);
      pa_n   = (base & ~om) | (va_low & om);
      if (!lk_any)            exc_n = lk_st ? EXC_RFL_ST : EXC_RFL_LD;
      else if (!h_v)          exc_n = lk_st ? EXC_INV_ST : EXC_INV_LD;
      else if (lk_st && !h_d) exc_n = EXC_MOD;
      else                    exc_n = EXC_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_done <= 1'b0;
         lk_pa   <= '0;
         lk_exc  <= EXC_NONE;
      end else begin
         lk_done <= lk_req;
         if (lk_req) begin
            lk_exc <= exc_n;
            lk_pa  <= (exc_n == EXC_NONE) ? pa_n : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_done  <= 1'b0;
         pr_found <= 1'b0;
         pr_idx   <= '0;
         mm_err   <= 1'b0;
      end else begin
         pr_done <= pr_req;
         if (pr_req) begin
            pr_found <= pr_any;
            pr_idx   <= pr_sel;
            if (pr_multi) mm_err <= 1'b1;
         end
      end
   end

   // the multiple-match flag never clears outside reset
   assert_mm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mm_err |=> mm_err);
   // the flag only rises together with a probe answer
   assert_mm_on_probe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mm_err) |-> pr_done);
   // a modified exception only ever answers a store
   assert_mod_is_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_exc == EXC_MOD) |-> $past(lk_st));
   // load-type codes only ever answer loads
   assert_load_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && (lk_exc == EXC_INV_LD || lk_exc == EXC_RFL_LD)) |-> !$past(lk_st));
   // store-type refill only ever answers stores
   assert_refill_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_exc == EXC_RFL_ST) |-> $past(lk_st));
   // the smallest page offset always passes through on a hit
   assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_exc == EXC_NONE) |-> (lk_pa[OFF_MIN-1:0] == $past(lk_va[OFF_MIN-1:0])));
endmodule

// File: tb/sim_sw_tlb.sv
module sim_sw_tlb;
   localparam int N = 12;
   localparam int IW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_req = 0, lk_st = 0, lk_done;
   logic [31:0] lk_va = '0, lk_pa;
   logic [7:0]  lk_asid = '0;
   logic [2:0]  lk_exc;
   logic wr_en = 0, wr_g = 0, wr_v0 = 0, wr_d0 = 0, wr_v1 = 0, wr_d1 = 0;
   logic [IW-1:0] wr_idx = '0, rd_idx = '0, pr_idx;
   logic [20:0] wr_vpn2 = '0, rd_vpn2, pr_vpn2 = '0;
   logic [3:0]  wr_size = '0, rd_size;
   logic [7:0]  wr_asid = '0, rd_asid, pr_asid = '0;
   logic [21:0] wr_pfn0 = '0, wr_pfn1 = '0, rd_pfn0, rd_pfn1;
   logic rd_g, rd_v0, rd_d0, rd_v1, rd_d1;
   logic pr_req = 0, pr_done, pr_found, mm_err;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;   // 125 MHz

   sw_tlb #(.N(N)) u0 (
      .clk, .rst_n, .lk_req, .lk_va, .lk_asid, .lk_st, .lk_done, .lk_pa, .lk_exc,
      .wr_en, .wr_idx, .wr_vpn2, .wr_size, .wr_asid, .wr_g, .wr_pfn0, .wr_v0, .wr_d0,
      .wr_pfn1, .wr_v1, .wr_d1, .rd_idx, .rd_vpn2, .rd_size, .rd_asid, .rd_g,
      .rd_pfn0, .rd_v0, .rd_d0, .rd_pfn1, .rd_v1, .rd_d1,
      .pr_req, .pr_vpn2, .pr_asid, .pr_done, .pr_found, .pr_idx, .mm_err
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ent(input int idx, input logic [20:0] vpn2, input logic [3:0] sz,
                         input logic [7:0] asid, input logic g,
                         input logic [21:0] p0, input logic v0, input logic d0,
                         input logic [21:0] p1, input logic v1, input logic d1);
      @(negedge clk);
      wr_en = 1; wr_idx = IW'(idx); wr_vpn2 = vpn2; wr_size = sz; wr_asid = asid; wr_g = g;
      wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic st,
                       input logic [2:0] e_exc, input logic [31:0] e_pa, input string req);
      @(negedge clk);
      lk_req = 1; lk_va = va; lk_asid = asid; lk_st = st;
      @(negedge clk);
      lk_req = 0;
      chk(lk_done === 1'b1, {req, " done"}, 64'(lk_done), 64'd1);
      chk(lk_exc === e_exc, {req, " exc"}, 64'(lk_exc), 64'(e_exc));
      chk(lk_pa === e_pa, {req, " pa"}, 64'(lk_pa), 64'(e_pa));
   endtask

   task automatic probe(input logic [20:0] vpn2, input logic [7:0] asid, input logic e_found,
                        input int e_idx, input logic e_mm, input string req);
      @(negedge clk);
      pr_req = 1; pr_vpn2 = vpn2; pr_asid = asid;
      @(negedge clk);
      pr_req = 0;
      chk(pr_done === 1'b1 && pr_found === e_found, {req, " found"}, 64'(pr_found), 64'(e_found));
      if (e_found) chk(pr_idx === IW'(e_idx), {req, " idx"}, 64'(pr_idx), 64'(e_idx));
      chk(mm_err === e_mm, {req, " multi"}, 64'(mm_err), 64'(e_mm));
   endtask

   task automatic t_reset;   // R11
      rd_idx = 4'd0; #1;
      chk(rd_vpn2 == 0 && rd_v0 == 0 && rd_pfn1 == 0 && rd_g == 0, "R11 entry zero", 64'(rd_vpn2), 64'd0);
      chk(lk_done == 0 && lk_pa == 0 && lk_exc == 0 && pr_done == 0 && mm_err == 0,
          "R11 outputs zero", 64'(lk_pa), 64'd0);
      look(32'h8000_0000, 8'd1, 0, 3'd4, 32'h0, "R11 R5 refill load");
   endtask

   task automatic t_small_page;   // R2 R3 R4 R6 R5 R10, 4 KB pair at entry 2
      wr_ent(2, 21'h804, 4'd1, 8'd5, 0, 22'h1000, 1, 1, 22'h2000, 1, 0);
      look(32'h0040_2ABC, 8'd5, 0, 3'd0, 32'h0040_0ABC, "R3 R10 even half");
      @(negedge clk);
      chk(lk_done === 1'b0, "R10 done pulse", 64'(lk_done), 64'd0);
      look(32'h0040_3123, 8'd5, 0, 3'd0, 32'h0080_0123, "R3 odd half");
      look(32'h0040_3123, 8'd5, 1, 3'd1, 32'h0, "R6 store clean");
      look(32'h0040_2ABC, 8'd5, 1, 3'd0, 32'h0040_0ABC, "R6 store dirty");
      look(32'h0040_2ABC, 8'd6, 0, 3'd4, 32'h0, "R4 asid mismatch load");
      look(32'h0040_2ABC, 8'd6, 1, 3'd5, 32'h0, "R4 R5 refill store");
      look(32'h0040_0ABC, 8'd5, 0, 3'd4, 32'h0, "R4 tag bit above pair");
   endtask

   task automatic t_global;   // R4 R7, 1 KB global pair at entry 5
      wr_ent(5, 21'h20000, 4'd0, 8'd0, 1, 22'h3, 1, 1, 22'h7, 0, 0);
      look(32'h1000_0155, 8'd9, 0, 3'd0, 32'h0000_0D55, "R4 global hit");
      look(32'h1000_0555, 8'd9, 0, 3'd2, 32'h0, "R7 invalid load");
      look(32'h1000_0555, 8'd9, 1, 3'd3, 32'h0, "R7 invalid store");
   endtask

   task automatic t_huge;   // R2 R3, 256 MB pair at entry 7
      wr_ent(7, 21'h40000, 4'd9, 8'd0, 1, 22'h100000, 1, 1, 22'h200000, 1, 1);
      look(32'h2ABC_DEF0, 8'd3, 0, 3'd0, 32'h4ABC_DEF0, "R2 256MB even");
      look(32'h3123_4567, 8'd3, 1, 3'd0, 32'h8123_4567, "R2 R3 256MB odd");
   endtask

   task automatic t_write_timing;   // R9
      @(negedge clk);
      wr_en = 1; wr_idx = 4'd9; wr_vpn2 = 21'hA0000; wr_size = 0; wr_asid = 0; wr_g = 1;
      wr_pfn0 = 22'h10; wr_v0 = 1; wr_d0 = 1; wr_pfn1 = 0; wr_v1 = 0; wr_d1 = 0;
      lk_req = 1; lk_va = 32'h5000_0011; lk_asid = 0; lk_st = 0;
      @(negedge clk);
      wr_en = 0; lk_req = 0;
      chk(lk_exc === 3'd4, "R9 same-cycle old contents", 64'(lk_exc), 64'd4);
      look(32'h5000_0011, 8'd0, 0, 3'd0, 32'h0000_4011, "R9 next-cycle new contents");
      rd_idx = 4'd2; #1;
      chk(rd_vpn2 == 21'h804 && rd_size == 4'd1 && rd_asid == 8'd5, "R9 read tag", 64'(rd_vpn2), 64'h804);
      chk(rd_pfn1 == 22'h2000 && rd_v1 && !rd_d1 && rd_d0, "R9 read halves", 64'(rd_pfn1), 64'h2000);
   endtask

   task automatic t_range;   // R1
      wr_ent(13, 21'hC0000, 4'd0, 8'd0, 1, 22'h1, 1, 1, 22'h1, 1, 1);
      look(32'h6000_0000, 8'd0, 0, 3'd4, 32'h0, "R1 out-of-range write ignored");
      rd_idx = 4'd13; #1;
      chk(rd_vpn2 == 0 && rd_v0 == 0 && rd_g == 0 && rd_pfn0 == 0, "R1 out-of-range read zero",
          64'(rd_vpn2), 64'd0);
   endtask

   task automatic t_probe;   // R8 R10
      probe(21'h804, 8'd5, 1, 2, 0, "R8 probe hit");
      probe(21'h804, 8'd6, 0, 0, 0, "R8 probe miss");
      wr_ent(10, 21'h804, 4'd1, 8'd5, 0, 22'h5000, 1, 1, 22'h5000, 1, 1);
      probe(21'h804, 8'd5, 1, 2, 1, "R8 lowest index and multi");
      probe(21'h1F0F0, 8'd1, 0, 0, 1, "R8 multi sticky");
      look(32'h0040_2ABC, 8'd5, 0, 3'd0, 32'h0040_0ABC, "R10 lowest index lookup");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_small_page();
      t_global();
      t_huge();
      t_write_timing();
      t_range();
      t_probe();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule